// File: doc/BRIEF.md
# I2C Clock-Stretch Wait Release Controller

This block owns the clock-stretch wait of an I2C bus interface. When the byte engine reaches a byte or acknowledge boundary it signals a wait entry, and the block then holds SCL low until software ends the wait. Software actions arrive as one-cycle pulses from a register interface: a data-register write, a wait-release bit, a start request, a stop request, a bus-release bit and a clear of the interface-enable bit. A wake-up-mode level flag is also an input.

Each accepted cancel ends the wait and tells the byte engine how to resume: transmit the newly written byte, receive the next byte or close a transmission, issue a repeated start, issue a stop, drop off the bus, or shut the interface down. Only the first cancel in a wait period is honoured. A later cancel before the next boundary is reported as an error and has no effect. Start and stop are master-only requests. While wake-up mode is active, no cancel is accepted.

Top module: `i2c_wait_release`

## Requirements
- R1: A `wait_enter_i` pulse while not waiting raises `scl_hold_o` at the next clock edge. Cancel requests made before any wait has been entered produce no action and no error flag.
- R2: A data write while waiting drops `scl_hold_o` one clock later and emits action code 1 (transmit).
- R3: A wait-release while waiting drops `scl_hold_o` one clock later and emits action code 2 (receive / finish transmit).
- R4: In master mode (`master_i`=1), a start request while waiting emits code 3 (repeated start), and a stop request emits code 4 (stop). Each ends the wait one clock later.
- R5: In slave mode, start and stop requests leave the wait in place and emit no action. `illegal_req_o` pulses high for exactly one cycle, one clock after the request.
- R6: Clearing the interface enable while waiting ends the wait and emits code 6 (disable).
- R7: A bus release while waiting ends the wait and emits code 5 (release).
- R8: While `wake_mode_i`=1, every cancel request is ignored: `scl_hold_o` stays high and no action or error flag is produced.
- R9: After a cancel, any further cancel request before the next wait entry produces a one-cycle `double_cancel_o` pulse one clock later, emits no action, and leaves `scl_hold_o` low.
- R10: When several requests arrive in one cycle, exactly one is acted on, in the priority order enable-clear, bus-release, stop, start, data write, wait-release. Start and stop made in slave mode do not take part.
- R11: `action_valid_o` is a single-cycle pulse. `action_o` is 0 whenever no action is reported.
- R12: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| master_i | input | 1 | 1 when the interface is bus master |
| wait_enter_i | input | 1 | Byte/ack boundary pulse from the byte engine |
| data_wr_i | input | 1 | Data register write pulse |
| wait_rel_i | input | 1 | Wait-release bit pulse |
| start_req_i | input | 1 | Start request pulse |
| stop_req_i | input | 1 | Stop request pulse |
| bus_rel_i | input | 1 | Bus-release bit pulse |
| en_clr_i | input | 1 | Interface-enable cleared pulse |
| wake_mode_i | input | 1 | Wake-up mode level flag |
| scl_hold_o | output | 1 | Hold SCL low (wait active) |
| action_valid_o | output | 1 | Resume action strobe |
| action_o | output | 3 | Resume action code |
| double_cancel_o | output | 1 | Second cancel in one wait period |
| illegal_req_o | output | 1 | Start/stop requested in slave mode |

## Verification
Every registered result appears at the first rising edge after the input pulse. This covers the SCL hold change, the action strobe and code, the double-cancel flag and the illegal flag. The bench drives each pulse on a falling edge and removes it on the next falling edge. It samples outputs at that second falling edge, which is half a cycle after the edge that registered them. It samples once more a cycle later to confirm that the strobes last exactly one cycle and that the hold level persists.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

    localparam int NUM_SRC = 6;
    localparam int ACT_W   = 3;

    // request index = priority rank, 0 highest
    localparam int IDX_EN_CLR  = 0;
    localparam int IDX_BUS_REL = 1;
    localparam int IDX_STOP    = 2;
    localparam int IDX_START   = 3;
    localparam int IDX_DATA_WR = 4;
    localparam int IDX_WREL    = 5;

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE    = 3'd0,
        ACT_TX      = 3'd1,
        ACT_RX      = 3'd2,
        ACT_RESTART = 3'd3,
        ACT_STOP    = 3'd4,
        ACT_RELEASE = 3'd5,
        ACT_DISABLE = 3'd6
    } act_e;

    function automatic act_e src_action(input int idx);
        case (idx)
            IDX_EN_CLR:  return ACT_DISABLE;
            IDX_BUS_REL: return ACT_RELEASE;
            IDX_STOP:    return ACT_STOP;
            IDX_START:   return ACT_RESTART;
            IDX_DATA_WR: return ACT_TX;
            IDX_WREL:    return ACT_RX;
            default:     return ACT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wr_req_filter.sv
module wr_req_filter
    import i2c_wr_pkg::*;
(
    input  logic [NUM_SRC-1:0] req_raw_i,
    input  logic               master_i,
    input  logic               wake_mode_i,
    output logic [NUM_SRC-1:0] req_ok_o,
    output logic               illegal_o
);
    logic [NUM_SRC-1:0] mode_mask;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_mask
            if (g == IDX_STOP || g == IDX_START) begin : g_master_only
                assign mode_mask[g] = master_i;
            end else begin : g_any_mode
                assign mode_mask[g] = 1'b1;
            end
        end
    endgenerate

    assign req_ok_o  = wake_mode_i ? '0 : (req_raw_i & mode_mask);
    assign illegal_o = ~wake_mode_i & ~master_i &
                       (req_raw_i[IDX_STOP] | req_raw_i[IDX_START]);
endmodule

// File: rtl/wr_prio_arb.sv
module wr_prio_arb #(
    parameter int N = 6
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    logic [N-1:0] seen;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_arb
            if (g == 0) begin : g_first
                assign grant_o[g] = req_i[g];
                assign seen[g]    = req_i[g];
            end else begin : g_rest
                assign grant_o[g] = req_i[g] & ~seen[g-1];
                assign seen[g]    = seen[g-1] | req_i[g];
            end
        end
    endgenerate

    assign any_o = seen[N-1];
endmodule

// File: rtl/i2c_wait_release.sv
module i2c_wait_release
    import i2c_wr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             master_i,
    input  logic             wait_enter_i,
    input  logic             data_wr_i,
    input  logic             wait_rel_i,
    input  logic             start_req_i,
    input  logic             stop_req_i,
    input  logic             bus_rel_i,
    input  logic             en_clr_i,
    input  logic             wake_mode_i,
    output logic             scl_hold_o,
    output logic             action_valid_o,
    output logic [ACT_W-1:0] action_o,
    output logic             double_cancel_o,
    output logic             illegal_req_o
);
    typedef struct packed {
        logic waiting;
        logic canceled;
        logic act_valid;
        act_e act;
        logic dbl;
        logic illegal;
    } state_t;

    localparam state_t RST_STATE = '{
        waiting:   1'b0,
        canceled:  1'b0,
        act_valid: 1'b0,
        act:       ACT_NONE,
        dbl:       1'b0,
        illegal:   1'b0
    };

    logic [NUM_SRC-1:0] req_raw;
    logic [NUM_SRC-1:0] req_ok;
    logic [NUM_SRC-1:0] grant;
    logic               grant_any;
    logic               illegal_d;

    always_comb begin
        req_raw              = '0;
        req_raw[IDX_EN_CLR]  = en_clr_i;
        req_raw[IDX_BUS_REL] = bus_rel_i;
        req_raw[IDX_STOP]    = stop_req_i;
        req_raw[IDX_START]   = start_req_i;
        req_raw[IDX_DATA_WR] = data_wr_i;
        req_raw[IDX_WREL]    = wait_rel_i;
    end

    wr_req_filter u_filter (
        .req_raw_i   (req_raw),
        .master_i    (master_i),
        .wake_mode_i (wake_mode_i),
        .req_ok_o    (req_ok),
        .illegal_o   (illegal_d)
    );

    wr_prio_arb #(.N(NUM_SRC)) u_arb (
        .req_i   (req_ok),
        .grant_o (grant),
        .any_o   (grant_any)
    );

    state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.act_valid = 1'b0;
        st_d.act       = ACT_NONE;
        st_d.dbl       = 1'b0;
        st_d.illegal   = illegal_d;
        if (st_q.waiting) begin
            if (grant_any) begin
                st_d.waiting   = 1'b0;
                st_d.canceled  = 1'b1;
                st_d.act_valid = 1'b1;
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (grant[i]) begin
                        st_d.act = src_action(i);
                    end
                end
            end
        end else if (wait_enter_i) begin
            st_d.waiting  = 1'b1;
            st_d.canceled = 1'b0;
        end else if (st_q.canceled && grant_any) begin
            st_d.dbl = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_hold_o      = st_q.waiting;
    assign action_valid_o  = st_q.act_valid;
    assign action_o        = st_q.act;
    assign double_cancel_o = st_q.dbl;
    assign illegal_req_o   = st_q.illegal;
endmodule

// File: rtl/i2c_wait_release_chk.sv
module i2c_wait_release_chk
    import i2c_wr_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             master_i,
    input logic             wake_mode_i,
    input logic             en_clr_i,
    input logic             start_req_i,
    input logic             stop_req_i,
    input logic             scl_hold_o,
    input logic             action_valid_o,
    input logic [ACT_W-1:0] action_o,
    input logic             double_cancel_o,
    input logic             illegal_req_o
);
    // R2
    hold_drop_has_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(scl_hold_o) |-> action_valid_o);

    // R11
    action_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        action_valid_o |=> !action_valid_o);

    // R11
    idle_code_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !action_valid_o |-> action_o == 3'd0);

    // R8
    wake_keeps_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(scl_hold_o) && $past(wake_mode_i)) |-> scl_hold_o);

    // R9
    dbl_excludes_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(double_cancel_o && action_valid_o));

    // R5
    illegal_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_req_o |-> $past(!master_i && !wake_mode_i && (start_req_i || stop_req_i)));

    // R10
    enable_clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(scl_hold_o && !wake_mode_i && en_clr_i) |-> (action_valid_o && action_o == 3'd6));
endmodule

bind i2c_wait_release i2c_wait_release_chk u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .master_i        (master_i),
    .wake_mode_i     (wake_mode_i),
    .en_clr_i        (en_clr_i),
    .start_req_i     (start_req_i),
    .stop_req_i      (stop_req_i),
    .scl_hold_o      (scl_hold_o),
    .action_valid_o  (action_valid_o),
    .action_o        (action_o),
    .double_cancel_o (double_cancel_o),
    .illegal_req_o   (illegal_req_o)
);

// File: tb/sim_i2c_wait_release.sv
`timescale 1ns/1ps
module sim_i2c_wait_release;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master = 1'b1;
    logic       wenter = 1'b0;
    logic       wake = 1'b0;
    logic [5:0] req = '0;   // {wrel, data, start, stop, bus_rel, en_clr}
    logic       hold, av, dbl, ill;
    logic [2:0] act;
    int         n_chk = 0;
    int         n_err = 0;

    always #10 clk = ~clk;

    i2c_wait_release u0 (
        .clk_i (clk), .rst_ni (rst_n), .master_i (master),
        .wait_enter_i (wenter),
        .data_wr_i (req[4]), .wait_rel_i (req[5]),
        .start_req_i (req[3]), .stop_req_i (req[2]),
        .bus_rel_i (req[1]), .en_clr_i (req[0]),
        .wake_mode_i (wake),
        .scl_hold_o (hold), .action_valid_o (av), .action_o (act),
        .double_cancel_o (dbl), .illegal_req_o (ill)
    );

    localparam logic [5:0] Q_ENC = 6'b000001, Q_BUS = 6'b000010,
                           Q_STP = 6'b000100, Q_STA = 6'b001000,
                           Q_DAT = 6'b010000, Q_WRL = 6'b100000;

    task automatic chk(input string rq, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: %s got=%0d exp=%0d", rq, what, got, exp);
        end
    endtask

    task automatic enter_wait(input string rq);
        @(negedge clk); wenter = 1'b1;
        @(negedge clk); wenter = 1'b0;
        chk(rq, "hold after entry", hold, 1);
    endtask

    // pulse requests for one cycle; outputs sampled at the following falling edge
    task automatic pulse(input logic [5:0] r);
        @(negedge clk); req = r;
        @(negedge clk); req = '0;
    endtask

    task automatic cancel_expect(input string rq, input logic [5:0] r, input int code);
        enter_wait(rq);
        pulse(r);
        chk(rq, "hold", hold, 0);
        chk(rq, "action_valid", av, 1);
        chk(rq, "action", act, code);
        @(negedge clk);
        chk(rq, "action_valid one cycle", av, 0);
        chk(rq, "action idle code", act, 0);
    endtask

    task automatic t_reset;
        chk("R12", "hold", hold, 0);
        chk("R12", "action_valid", av, 0);
        chk("R12", "double", dbl, 0);
        chk("R12", "illegal", ill, 0);
    endtask

    task automatic t_no_wait;
        pulse(Q_DAT);
        chk("R1", "action without wait", av, 0);
        chk("R1", "double without wait", dbl, 0);
        chk("R1", "hold", hold, 0);
    endtask

    task automatic t_basic;
        master = 1'b1;
        cancel_expect("R2", Q_DAT, 1);
        cancel_expect("R3", Q_WRL, 2);
        cancel_expect("R4", Q_STA, 3);
        cancel_expect("R4", Q_STP, 4);
        cancel_expect("R6", Q_ENC, 6);
        cancel_expect("R7", Q_BUS, 5);
        cancel_expect("R11", Q_DAT, 1);
    endtask

    task automatic t_slave;
        master = 1'b0;
        enter_wait("R5");
        pulse(Q_STA);
        chk("R5", "hold kept", hold, 1);
        chk("R5", "no action", av, 0);
        chk("R5", "illegal", ill, 1);
        @(negedge clk);
        chk("R5", "illegal one cycle", ill, 0);
        pulse(Q_STP);
        chk("R5", "hold kept stop", hold, 1);
        chk("R5", "illegal stop", ill, 1);
        pulse(Q_WRL);
        chk("R5", "wrel after slave start", act, 2);
        chk("R5", "hold released", hold, 0);
        master = 1'b1;
    endtask

    task automatic t_wake;
        wake = 1'b1;
        enter_wait("R8");
        pulse(Q_DAT);
        chk("R8", "hold kept", hold, 1);
        chk("R8", "no action", av, 0);
        pulse(Q_ENC | Q_BUS | Q_STP);
        chk("R8", "hold kept multi", hold, 1);
        chk("R8", "no action multi", av, 0);
        chk("R8", "no double", dbl, 0);
        repeat (3) @(negedge clk);
        chk("R8", "hold persists", hold, 1);
        wake = 1'b0;
        pulse(Q_WRL);
        chk("R8", "cancel after wake off", act, 2);
    endtask

    task automatic t_double;
        enter_wait("R9");
        pulse(Q_WRL);
        chk("R9", "first cancel", act, 2);
        pulse(Q_DAT);
        chk("R9", "double flag", dbl, 1);
        chk("R9", "no action", av, 0);
        chk("R9", "hold stays low", hold, 0);
        @(negedge clk);
        chk("R9", "double one cycle", dbl, 0);
        enter_wait("R9");
        pulse(Q_DAT);
        chk("R9", "fresh wait accepts", act, 1);
        chk("R9", "fresh no double", dbl, 0);
    endtask

    task automatic t_prio;
        master = 1'b1;
        cancel_expect("R10", 6'b111111, 6);
        cancel_expect("R10", 6'b111110, 5);
        cancel_expect("R10", 6'b111100, 4);
        cancel_expect("R10", 6'b111000, 3);
        cancel_expect("R10", 6'b110000, 1);
        master = 1'b0;
        enter_wait("R10");
        pulse(Q_STP | Q_DAT | Q_WRL);
        chk("R10", "slave stop skipped", act, 1);
        chk("R10", "slave illegal", ill, 1);
        master = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog: run hung got=1 exp=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_wait();
        t_basic();
        t_slave();
        t_wake();
        t_double();
        t_prio();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule